// File: doc/BRIEF.md
# Character-Decimal to Packed-BCD Converter

This block turns a 128-bit vector of eight 16-bit decimal characters into a signed packed-BCD value. The lowest halfword holds a sign character and the seven halfwords above it hold digit characters. Each valid digit character gives one BCD nibble, and the sign character gives the sign nibble at the bottom of the result. A select input chooses between the two encodings for a positive sign.

Alongside the packed value, the block produces a one-hot 4-bit condition field. The field says whether the result is zero, positive or negative, or it says that the input was malformed. A caller pulses `in_vld` with the source and the select bit. On the next clock edge the block registers the result and condition field and raises `done` for one cycle. The outputs keep their values until the next strobe.

Top module: `natdec_to_bcd`

## Requirements
- R1: A synchronous active-high `rst` clears `bcd_out`, `cc` and `done` to zero.
- R2: The block captures `bcd_out` and `cc` on the clock edge where `in_vld` is high and raises `done` for the following cycle. Without a strobe, `done` stays low and `bcd_out` and `cc` hold their values.
- R3: For i from 1 to 7, a digit halfword `src[16i+15:16i]` in the range 0x0030 to 0x0039 places its low four bits in result nibble `bcd_out[4i+3:4i]`, provided every lower digit halfword was also in range.
- R4: The lowest digit halfword outside 0x0030 to 0x0039 makes the input invalid. Its result nibble and every higher digit nibble are zero.
- R5: The sign nibble `bcd_out[3:0]` is 0xC when `src[15:0]` is 0x002B and `pref_sgn` is 0. It is 0xF when `src[15:0]` is 0x002B and `pref_sgn` is 1. It is 0xD for any other sign halfword.
- R6: Any sign halfword other than 0x002B or 0x002D makes the input invalid.
- R7: `cc` is laid out as {LT, GT, EQ, SO} in bits 3 down to 0 with exactly one bit set. For a valid input whose nibbles 1 to 31 are all zero, `cc` is 4'b0010 (EQ), whatever the sign.
- R8: For a valid input with a nonzero magnitude, `cc` is 4'b0100 (GT) when the sign nibble is 0xA, 0xC, 0xE or 0xF. It is 4'b1000 (LT) when the sign nibble is 0xB or 0xD.
- R9: For an invalid input, `cc` is 4'b0001 (SO) alone, and `bcd_out` is still updated as given by R3 to R5.
- R10: Result nibbles 8 through 31 (`bcd_out[127:32]`) are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Strobe: `src` and `pref_sgn` are valid this cycle |
| src | input | 128 | Eight 16-bit characters; sign character in bits 15:0 |
| pref_sgn | input | 1 | Selects the positive sign nibble: 0 gives 0xC, 1 gives 0xF |
| bcd_out | output | 128 | Packed-BCD result, sign nibble in bits 3:0 |
| cc | output | 4 | Condition field {LT, GT, EQ, SO} |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
A broken digit-scan chain shows up at the ports as stray digits above a rejected character, or as a missing SO flag. It is visible in `bcd_out` and `cc` in the cycle right after the strobe. A wrong sign decode shows in the same cycle, in the sign nibble and in the LT/GT choice, including the rule that a zero magnitude gives EQ for both signs. A faulty capture or strobe path shows as a missing `done` pulse, an extra `done` pulse, or outputs that drift between strobes. The scoreboard and the hold checks catch these on the first idle cycle.

// File: rtl/natdec_to_bcd.sv
module natdec_to_bcd #(
  parameter int CH_W  = 16,
  parameter int N_CH  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [CH_W*N_CH-1:0] src,
  input  logic                 pref_sgn,
  output logic [CH_W*N_CH-1:0] bcd_out,
  output logic [3:0]           cc,
  output logic                 done
);
  localparam int W     = CH_W * N_CH;
  localparam int N_DIG = N_CH - 1;
  localparam int MAG_W = 4 * N_DIG;

  localparam logic [CH_W-1:0] CH_PLUS  = CH_W'(16'h002B);
  localparam logic [CH_W-1:0] CH_MINUS = CH_W'(16'h002D);
  localparam logic [CH_W-1:0] CH_ZERO  = CH_W'(16'h0030);
  localparam logic [CH_W-1:0] CH_NINE  = CH_W'(16'h0039);

  logic [CH_W-1:0]  sgn_ch, ch;
  logic [MAG_W-1:0] mag;
  logic             run_ok, is_plus, is_minus, bad, neg;
  logic [3:0]       sgn_nib, cc_n;

  assign sgn_ch   = src[CH_W-1:0];
  assign is_plus  = (sgn_ch == CH_PLUS);
  assign is_minus = (sgn_ch == CH_MINUS);

  always_comb begin
    run_ok = 1'b1;
    mag    = '0;
    ch     = '0;
    for (int i = 1; i <= N_DIG; i++) begin
      ch     = src[CH_W*i +: CH_W];
      run_ok = run_ok && (ch >= CH_ZERO) && (ch <= CH_NINE);
      if (run_ok) mag[4*(i-1) +: 4] = ch[3:0];
    end
  end

  assign sgn_nib = is_plus ? (pref_sgn ? 4'hF : 4'hC) : 4'hD;
  assign neg     = (sgn_nib == 4'hB) || (sgn_nib == 4'hD);
  assign bad     = !(is_plus || is_minus) || !run_ok;

  assign cc_n = bad        ? 4'b0001 :
                (mag == '0) ? 4'b0010 :
                neg        ? 4'b1000 : 4'b0100;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcd_out <= '0;
      cc      <= '0;
      done    <= 1'b0;
    end else begin
      done <= in_vld;
      if (in_vld) begin
        bcd_out <= {{(W-MAG_W-4){1'b0}}, mag, sgn_nib};
        cc      <= cc_n;
      end
    end
  end
endmodule

// File: rtl/natdec_to_bcd_chk.sv
module natdec_to_bcd_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_vld,
  input logic [127:0] src,
  input logic [127:0] bcd_out,
  input logic [3:0]   cc,
  input logic         done
);
  AST_DONE_AFTER_VLD: assert property (@(posedge clk) disable iff (rst) in_vld |=> done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !done); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_vld |=> ($stable(bcd_out) && $stable(cc))); // R2
  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (rst) done |-> ($countones(cc) == 1)); // R7
  AST_EQ_ZERO_MAG: assert property (@(posedge clk) disable iff (rst) (done && cc[1]) |-> (bcd_out[127:4] == '0)); // R7
  AST_NONPLUS_SIGN: assert property (@(posedge clk) disable iff (rst) (in_vld && src[15:0] != 16'h002B) |=> (bcd_out[3:0] == 4'hD)); // R5
  AST_BAD_SIGN_SO: assert property (@(posedge clk) disable iff (rst) (in_vld && src[15:0] != 16'h002B && src[15:0] != 16'h002D) |=> (cc == 4'b0001)); // R6
endmodule

bind natdec_to_bcd natdec_to_bcd_chk u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .src(src),
  .bcd_out(bcd_out), .cc(cc), .done(done)
);

// File: tb/natdec_to_bcd_test.sv
module natdec_to_bcd_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [127:0] src = '0;
  logic         pref_sgn = 1'b0;
  logic [127:0] bcd_out;
  logic [3:0]   cc;
  logic         done;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int seen = 0;
  logic [131:0] exp_q[$];
  string        tag_q[$];
  logic [131:0] last_exp = '0;

  always #5 clk = ~clk;

  natdec_to_bcd uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .src(src), .pref_sgn(pref_sgn),
    .bcd_out(bcd_out), .cc(cc), .done(done)
  );

  function automatic logic [131:0] model(input logic [127:0] s, input logic p);
    logic [127:0] r;
    logic [15:0]  h;
    logic         bad, stop;
    logic [3:0]   c;
    r    = '0;
    stop = 1'b0;
    bad  = !(s[15:0] == 16'h002B || s[15:0] == 16'h002D);
    for (int i = 1; i < 8; i++) begin
      h = s[16*i +: 16];
      if (!stop) begin
        if (h >= 16'h0030 && h <= 16'h0039) r[4*i +: 4] = h[3:0];
        else begin stop = 1'b1; bad = 1'b1; end
      end
    end
    r[3:0] = (s[15:0] == 16'h002B) ? (p ? 4'hF : 4'hC) : 4'hD;
    if (bad) c = 4'b0001;
    else if (r[127:4] == '0) c = 4'b0010;
    else if (r[3:0] == 4'hB || r[3:0] == 4'hD) c = 4'b1000;
    else c = 4'b0100;
    return {c, r};
  endfunction

  task automatic check(input string tag, input logic [131:0] act, input logic [131:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [127:0] s, input logic p);
    @(negedge clk);
    src = s; pref_sgn = p; in_vld = 1'b1;
    exp_q.push_back(model(s, p));
    tag_q.push_back(tag);
    sent++;
    @(negedge clk);
    in_vld = 1'b0;
    src = {8{16'hFFFF}};
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      seen++;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: done with no pending item, actual 1 expected 0");
      end else begin
        last_exp = exp_q.pop_front();
        check(tag_q.pop_front(), {cc, bcd_out}, last_exp);
        check("R10 upper zero", {4'b0, bcd_out[127:32]}, '0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {cc, bcd_out}, '0);
    check("R1 reset done", {131'b0, done}, '0);
    rst = 1'b0;

    send("R3 R8 plus digits GT",
      {16'h0037,16'h0036,16'h0035,16'h0034,16'h0033,16'h0032,16'h0031,16'h002B}, 1'b0);
    send("R5 R8 minus digits LT",
      {16'h0039,16'h0030,16'h0038,16'h0031,16'h0037,16'h0032,16'h0036,16'h002D}, 1'b0);
    send("R5 R7 plus zero pref EQ",
      {16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h002B}, 1'b1);
    send("R7 minus zero EQ",
      {16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h002D}, 1'b1);
    send("R6 R9 bad sign SO",
      {16'h0031,16'h0032,16'h0033,16'h0034,16'h0035,16'h0036,16'h0037,16'h0041}, 1'b1);
    send("R4 R9 digit3 over",
      {16'h0031,16'h0031,16'h0031,16'h0031,16'h003A,16'h0038,16'h0039,16'h002B}, 1'b0);
    send("R4 digit1 under",
      {16'h0031,16'h0032,16'h0033,16'h0034,16'h0035,16'h0036,16'h002F,16'h002D}, 1'b0);
    send("R4 high byte set",
      {16'h0131,16'h0032,16'h0033,16'h0034,16'h0035,16'h0036,16'h0037,16'h002B}, 1'b1);
    send("R3 R5 pref F GT",
      {16'h0039,16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h002B}, 1'b1);

    @(negedge clk);
    src = {16'h0031,16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h002D};
    pref_sgn = 1'b0; in_vld = 1'b1;
    exp_q.push_back(model(src, 1'b0)); tag_q.push_back("R2 back-to-back first"); sent++;
    @(negedge clk);
    src = {16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h0030,16'h0035,16'h002B};
    exp_q.push_back(model(src, 1'b0)); tag_q.push_back("R2 back-to-back second"); sent++;
    @(negedge clk);
    in_vld = 1'b0;

    repeat (4) @(negedge clk);
    check("R2 hold idle", {cc, bcd_out}, last_exp);
    check("R2 no done idle", {131'b0, done}, '0);
    check("R2 done count", 132'(seen), 132'(sent));
    check("R2 queue drained", 132'(exp_q.size()), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule